// File: doc/BRIEF.md
# Linked-List Shared-Buffer Queue Manager

This block keeps one first-in first-out logical queue per output inside a single shared cell memory. Storage is a pool of cell locations. A free-address FIFO hands out vacant locations to arriving cells and takes back the locations of departing cells. Each queue is a singly linked chain. A per-queue head register names the oldest cell and a per-queue tail register names the newest stored cell. A next-pointer array holds the link from each cell to its successor.

A write request carries a cell word and a destination queue. The cell goes into the location at the front of the free FIFO. That location is linked behind the current tail, and the tail register then moves to it. A read request names a queue. It returns the cell at that queue's head together with the location it came from, advances the head along the link, and recycles the location. The tail always points at a real stored cell, so every location in the pool can hold a cell and no spare slot is set aside per queue. One write and one read may be issued in the same cycle. All responses are registered and appear on the cycle after the request.

Top module: `lq_shared_buffer`

## Requirements
- R1: After synchronous reset every queue reports empty (`q_empty` all ones), `buf_full` is 0, and the free FIFO holds every location in ascending order, so the first writes after reset land at locations 0, 1, 2 and so on.
- R2: A write issued while a free location exists is accepted. On the next cycle `wr_ack` is 1 and `wr_addr` shows the location taken from the front of the free FIFO. `wr_ack` and `wr_nack` are never 1 together.
- R3: Reads of one queue return its cells in the order they were written. Each new cell is linked from the previous tail location.
- R4: A write to an empty queue makes the new location both head and tail, and `q_empty` for that queue goes to 0 on the next cycle.
- R5: A read of a non-empty queue gives, on the next cycle, `rd_valid`=1, the head cell on `rd_data` and its location on `rd_addr`. The head then moves to the linked successor.
- R6: A read that removes the only cell of a queue sets that queue's `q_empty` bit on the next cycle.
- R7: The location freed by a read joins the back of the free FIFO. Locations are therefore reused in the order they were freed, after any locations that were already free.
- R8: When no location is free, `buf_full` is 1. A write is then refused with `wr_nack`=1 on the next cycle, and nothing is stored or linked. This holds even if a read in the same cycle frees a location.
- R9: A read of an empty queue gives `rd_nack`=1 and `rd_valid`=0 on the next cycle, and leaves all queue and free-list state unchanged.
- R10: A write and a read in the same cycle are both served. This includes the case where both target the same queue and that queue holds exactly one cell: the old cell is returned and the new cell becomes the sole content.
- R11: All DEPTH locations can be filled from any mix of queues (16 for the default build) before `buf_full` rises. No location is reserved per queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_qid | input | QID_W (2) | Destination queue of the write |
| wr_data | input | DATA_W (16) | Cell word to store |
| rd_en | input | 1 | Read request |
| rd_qid | input | QID_W (2) | Queue to read from |
| wr_ack | output | 1 | Previous-cycle write stored |
| wr_nack | output | 1 | Previous-cycle write refused, buffer full |
| wr_addr | output | ADDR_W (4) | Location used by the acknowledged write |
| rd_valid | output | 1 | Previous-cycle read returned a cell |
| rd_nack | output | 1 | Previous-cycle read hit an empty queue |
| rd_data | output | DATA_W (16) | Cell word returned by the read |
| rd_addr | output | ADDR_W (4) | Location the returned cell came from |
| q_empty | output | NUM_OUT (4) | One bit per queue, 1 when the queue holds no cell |
| buf_full | output | 1 | No free location remains |

## Verification
A wrong internal link, head or tail shows up as a wrong `rd_addr` or `rd_data` on the first read that walks across the bad link. That read comes one cycle after the request, but it may come many operations after the corruption. For that reason the sequences drain every queue completely and compare every returned location against an independent model of the chains. A wrong free-list entry shows up as a wrong `wr_addr` on the first write that pops it, which is one cycle after that write. A wrong count or valid flag shows up at once on `buf_full` or `q_empty`, which are compared after every cycle.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

  // Outcome of a request, held for one cycle in the response registers
  typedef enum logic [1:0] {
    RSP_NONE    = 2'd0,
    RSP_OK      = 2'd1,
    RSP_REFUSED = 2'd2
  } rsp_e;

endpackage

// File: rtl/lqm_ram.sv
// Simple dual-port word memory. SYNC_RD=1 gives a registered read (block RAM),
// SYNC_RD=0 gives a combinational read (distributed RAM).
module lqm_ram #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 16,
  parameter bit SYNC_RD = 1'b1,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (SYNC_RD) begin : g_sync
      logic [WIDTH-1:0] rq;
      always_ff @(posedge clk) begin
        if (re) rq <= mem[raddr];
      end
      assign rdata = rq;
    end else begin : g_async
      logic unused_re;
      assign unused_re = re;
      assign rdata     = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/lqm_free_fifo.sv
// Circular list of vacant locations, loaded with every address at reset.
module lqm_free_fifo #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] front_addr,
  output logic          empty
);

  logic [AW-1:0] slot [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] count, count_nx;

  always_comb begin
    count_nx = count;
    if (push && !pop) count_nx = count + CW'(1);
    if (pop && !push) count_nx = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= AW'(i);
      rptr  <= '0;
      wptr  <= '0;
      count <= CW'(DEPTH);
      empty <= 1'b0;
    end else begin
      if (push) begin
        slot[wptr] <= push_addr;
        wptr       <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      end
      if (pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count_nx;
      empty <= (count_nx == '0);
    end
  end

  assign front_addr = slot[rptr];

endmodule

// File: rtl/lqm_qptr.sv
// Per-queue head, tail and occupied flag.
module lqm_qptr #(
  parameter int NUM_OUT = 4,
  parameter int AW      = 4,
  localparam int QW     = $clog2(NUM_OUT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enq,
  input  logic [QW-1:0]              enq_q,
  input  logic [AW-1:0]              enq_addr,
  input  logic                       deq,
  input  logic [QW-1:0]              deq_q,
  input  logic [AW-1:0]              deq_next,
  output logic [NUM_OUT-1:0][AW-1:0] head_o,
  output logic [NUM_OUT-1:0][AW-1:0] tail_o,
  output logic [NUM_OUT-1:0]         valid_o
);

  generate
    for (genvar q = 0; q < NUM_OUT; q++) begin : g_q
      logic [AW-1:0] head, tail;
      logic          valid;
      logic          enq_here, deq_here;

      assign enq_here = enq && (enq_q == QW'(q));
      assign deq_here = deq && (deq_q == QW'(q));

      always_ff @(posedge clk) begin
        if (rst) begin
          head  <= '0;
          tail  <= '0;
          valid <= 1'b0;
        end else if (enq_here && deq_here) begin
          // queue is occupied (dequeue only issued then)
          tail <= enq_addr;
          head <= (head == tail) ? enq_addr : deq_next;
        end else if (enq_here) begin
          tail  <= enq_addr;
          valid <= 1'b1;
          if (!valid) head <= enq_addr;
        end else if (deq_here) begin
          if (head == tail) valid <= 1'b0;
          else              head  <= deq_next;
        end
      end

      assign head_o[q]  = head;
      assign tail_o[q]  = tail;
      assign valid_o[q] = valid;
    end
  endgenerate

endmodule

// File: rtl/lq_shared_buffer.sv
module lq_shared_buffer
  import lqm_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int QID_W  = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [QID_W-1:0]   wr_qid,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [QID_W-1:0]   rd_qid,
  output logic               wr_ack,
  output logic               wr_nack,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic               rd_valid,
  output logic               rd_nack,
  output logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [NUM_OUT-1:0] q_empty,
  output logic               buf_full
);

  logic [NUM_OUT-1:0][ADDR_W-1:0] head, tail;
  logic [NUM_OUT-1:0]             valid;
  logic [ADDR_W-1:0]              free_addr, link_next, head_sel;
  logic                           free_empty;
  logic                           wr_go, rd_go, link_we;
  rsp_e                           wr_rsp, rd_rsp;
  logic [ADDR_W-1:0]              wr_addr_q, rd_addr_q;

  assign wr_go    = wr_en && !free_empty;
  assign rd_go    = rd_en && valid[rd_qid];
  assign head_sel = head[rd_qid];
  // link behind the current tail only when the queue already holds a cell
  assign link_we  = wr_go && valid[wr_qid];

  lqm_free_fifo #(.DEPTH(DEPTH)) u_free (
    .clk       (clk),
    .rst       (rst),
    .pop       (wr_go),
    .push      (rd_go),
    .push_addr (head_sel),
    .front_addr(free_addr),
    .empty     (free_empty)
  );

  lqm_qptr #(.NUM_OUT(NUM_OUT), .AW(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .enq     (wr_go),
    .enq_q   (wr_qid),
    .enq_addr(free_addr),
    .deq     (rd_go),
    .deq_q   (rd_qid),
    .deq_next(link_next),
    .head_o  (head),
    .tail_o  (tail),
    .valid_o (valid)
  );

  lqm_ram #(.DEPTH(DEPTH), .WIDTH(ADDR_W), .SYNC_RD(1'b0)) u_link (
    .clk  (clk),
    .we   (link_we),
    .waddr(tail[wr_qid]),
    .wdata(free_addr),
    .re   (rd_go),
    .raddr(head_sel),
    .rdata(link_next)
  );

  lqm_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W), .SYNC_RD(1'b1)) u_cell (
    .clk  (clk),
    .we   (wr_go),
    .waddr(free_addr),
    .wdata(wr_data),
    .re   (rd_go),
    .raddr(head_sel),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_rsp    <= RSP_NONE;
      rd_rsp    <= RSP_NONE;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
    end else begin
      wr_rsp <= !wr_en ? RSP_NONE : (wr_go ? RSP_OK : RSP_REFUSED);
      rd_rsp <= !rd_en ? RSP_NONE : (rd_go ? RSP_OK : RSP_REFUSED);
      if (wr_go) wr_addr_q <= free_addr;
      if (rd_go) rd_addr_q <= head_sel;
    end
  end

  assign wr_ack   = (wr_rsp == RSP_OK);
  assign wr_nack  = (wr_rsp == RSP_REFUSED);
  assign rd_valid = (rd_rsp == RSP_OK);
  assign rd_nack  = (rd_rsp == RSP_REFUSED);
  assign wr_addr  = wr_addr_q;
  assign rd_addr  = rd_addr_q;
  assign q_empty  = ~valid;
  assign buf_full = free_empty;

endmodule

// File: rtl/lqm_checker.sv
module lqm_checker #(
  parameter int NUM_OUT = 4,
  localparam int QID_W  = $clog2(NUM_OUT)
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [QID_W-1:0]   rd_qid,
  input logic               wr_ack,
  input logic               wr_nack,
  input logic               rd_valid,
  input logic               rd_nack,
  input logic [NUM_OUT-1:0] q_empty,
  input logic               buf_full
);

  // R2: a write with a free location is accepted
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !buf_full) |=> wr_ack);

  // R2: never both answers
  p_ack_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_ack && wr_nack));

  // R8: refusal when no location is free
  p_refuse_full_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && buf_full) |=> (wr_nack && !wr_ack));

  // R8: without a read nothing can be freed
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !rd_en) |=> buf_full);

  // R5: a read of an occupied queue returns a cell
  p_read_ok_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !q_empty[rd_qid]) |=> (rd_valid && !rd_nack));

  // R9: a read of an empty queue is refused
  p_empty_nack_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && q_empty[rd_qid]) |=> (rd_nack && !rd_valid));

  // R9: an idle or refused read never frees a location
  p_no_free_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && buf_full && !wr_en && !rd_en) |=> buf_full);

endmodule

bind lq_shared_buffer lqm_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_qid  (rd_qid),
  .wr_ack  (wr_ack),
  .wr_nack (wr_nack),
  .rd_valid(rd_valid),
  .rd_nack (rd_nack),
  .q_empty (q_empty),
  .buf_full(buf_full)
);

// File: tb/lq_shared_buffer_test.sv
`timescale 1ns/1ps
module lq_shared_buffer_test;

  localparam int NQ = 4;
  localparam int DP = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en;
  logic [1:0]    wr_qid, rd_qid;
  logic [DW-1:0] wr_data;
  logic          wr_ack, wr_nack, rd_valid, rd_nack, buf_full;
  logic [3:0]    wr_addr, rd_addr;
  logic [DW-1:0] rd_data;
  logic [NQ-1:0] q_empty;

  always #2 clk = ~clk;

  lq_shared_buffer uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_qid(wr_qid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_qid(rd_qid),
    .wr_ack(wr_ack), .wr_nack(wr_nack), .wr_addr(wr_addr),
    .rd_valid(rd_valid), .rd_nack(rd_nack), .rd_data(rd_data), .rd_addr(rd_addr),
    .q_empty(q_empty), .buf_full(buf_full)
  );

  typedef struct {
    bit    wa, wn, rv, rn, bf;
    int    waddr, raddr, rdata;
    bit [NQ-1:0] qe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   free_l[$];
  int   dq[NQ][$];
  int   aq[NQ][$];
  int   checks = 0;
  int   fails  = 0;
  int   seq    = 0;
  bit   done   = 0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // driver: applies one cycle of stimulus and queues what must come back
  task automatic op(bit we, int wq, bit re, int rq, string tag);
    exp_t e;
    bit   rd_empty, no_free;
    int   d;
    @(negedge clk);
    d       = 16'hC000 + seq;
    seq++;
    wr_en   = we;
    wr_qid  = 2'(wq);
    wr_data = DW'(d);
    rd_en   = re;
    rd_qid  = 2'(rq);
    e.tag   = tag;
    e.wa = 0; e.wn = 0; e.rv = 0; e.rn = 0; e.waddr = 0; e.raddr = 0; e.rdata = 0;
    rd_empty = (dq[rq].size() == 0);
    no_free  = (free_l.size() == 0);
    if (we) begin
      if (no_free) e.wn = 1;
      else begin
        e.wa    = 1;
        e.waddr = free_l.pop_front();
        dq[wq].push_back(d);
        aq[wq].push_back(e.waddr);
      end
    end
    if (re) begin
      if (rd_empty) e.rn = 1;
      else begin
        e.rv    = 1;
        e.rdata = dq[rq].pop_front();
        e.raddr = aq[rq].pop_front();
        free_l.push_back(e.raddr);
      end
    end
    for (int q = 0; q < NQ; q++) e.qe[q] = (dq[q].size() == 0);
    e.bf = (free_l.size() == 0);
    exp_q.push_back(e);
  endtask

  task automatic idle(string tag);
    op(0, 0, 0, 0, tag);
  endtask

  // monitor: compares registered responses just after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      bit   bad;
      e   = exp_q.pop_front();
      bad = (wr_ack !== e.wa) || (wr_nack !== e.wn) || (rd_valid !== e.rv) ||
            (rd_nack !== e.rn) || (q_empty !== e.qe) || (buf_full !== e.bf) ||
            (e.wa && (int'(wr_addr) != e.waddr)) ||
            (e.rv && ((int'(rd_addr) != e.raddr) || (int'(rd_data) != e.rdata)));
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s: act ack=%0b nack=%0b waddr=%0d rv=%0b rn=%0b raddr=%0d rdata=%h qe=%b full=%0b | exp ack=%0b nack=%0b waddr=%0d rv=%0b rn=%0b raddr=%0d rdata=%h qe=%b full=%0b",
                 e.tag, wr_ack, wr_nack, wr_addr, rd_valid, rd_nack, rd_addr, rd_data, q_empty, buf_full,
                 e.wa, e.wn, e.waddr, e.rv, e.rn, e.raddr, e.rdata, e.qe, e.bf);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      finish_run();
    end
  end

  initial begin
    rst = 1; wr_en = 0; rd_en = 0; wr_qid = 0; rd_qid = 0; wr_data = 0;
    for (int i = 0; i < DP; i++) free_l.push_back(i);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    checks++;
    if (q_empty !== 4'hF || buf_full !== 1'b0 || wr_ack !== 1'b0 || rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: act qe=%b full=%0b ack=%0b rv=%0b exp qe=1111 full=0 ack=0 rv=0",
               q_empty, buf_full, wr_ack, rd_valid);
    end
    @(negedge clk);
    rst = 0;
    idle("R1");

    // R2 R4 R11: fill all locations; queue 1 ends at 0,3,6
    op(1, 1, 0, 0, "R4");
    op(1, 2, 0, 0, "R4");
    op(1, 2, 0, 0, "R2");
    op(1, 1, 0, 0, "R3");
    op(1, 2, 0, 0, "R2");
    op(1, 2, 0, 0, "R2");
    op(1, 1, 0, 0, "R3");
    for (int i = 0; i < 9; i++) op(1, 2, 0, 0, "R11");
    // R8: refused while full, also when a read frees in the same cycle
    op(1, 0, 0, 0, "R8");
    // R9: empty queue read changes nothing
    op(0, 0, 1, 0, "R9");
    op(1, 3, 1, 2, "R8");
    // R7: location 1 is freed, the next write must reuse it
    op(1, 1, 0, 0, "R7");
    // R3 R5 R6: drain queue 1 through 0,3,6,1
    op(0, 0, 1, 1, "R5");
    op(0, 0, 1, 1, "R3");
    op(0, 0, 1, 1, "R3");
    op(0, 0, 1, 1, "R6");
    op(0, 0, 1, 1, "R9");
    // R10: different queues in one cycle
    op(1, 3, 1, 2, "R10");
    op(1, 0, 1, 2, "R10");
    // R10: same queue holding one cell
    op(1, 0, 1, 0, "R10");
    op(1, 0, 1, 0, "R10");
    op(0, 0, 1, 0, "R6");
    // drain everything, then refill to exercise reuse order
    for (int i = 0; i < 12; i++) op(0, 0, 1, 2, "R3");
    op(0, 0, 1, 3, "R6");
    op(0, 0, 1, 3, "R6");
    for (int i = 0; i < DP; i++) op(1, i % NQ, 0, 0, "R7");
    op(1, 1, 0, 0, "R8");
    for (int i = 0; i < DP; i++) op(0, 0, 1, (i * 3) % NQ, "R3");
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule